// File: doc/BRIEF.md
# LCD Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, data enable, the column and row of the current active pixel, and a one-cycle strobe at the first pixel of every frame. It runs one step per pixel clock. All geometry comes from three packed 32-bit configuration words: one horizontal, one vertical, and one for polarity and line length. Most fields are stored minus one, and the line width is coded in units of 16 pixels.

Each axis moves through four phases in a fixed order: active, front porch, sync, back porch. The vertical axis moves forward once per completed line. The configuration words are copied into shadow storage at each frame boundary, so a write in the middle of a frame takes effect only from the next frame. Two control inputs, an enable and a panel-power bit, must both be high for the raster to run. While either is low, every output is held low, and the raster starts again from the first pixel of a frame.

Top module: `lcd_tgen`

## Requirements
- R1: Horizontal geometry is decoded from `tim_h` as follows. Active width is (tim_h[7:2]+1)*16 pixels. Sync width is tim_h[15:8]+1. Front porch is tim_h[23:16]+1. Back porch is tim_h[31:24]+1. Bits 1:0 are ignored.
- R2: Each line is the active pixels, then the front porch, then the sync, then the back porch. Before inversion, hsync is high only during the sync pixels.
- R3: Vertical geometry is decoded from `tim_v` as follows. Active lines are tim_v[9:0]+1. Sync lines are tim_v[15:10]+1. Front porch lines are tim_v[23:16], taken as stored. Back porch lines are tim_v[31:24], taken as stored. A porch of zero lines is skipped.
- R4: Lines follow the order active, front porch, sync, back porch. The vertical position moves forward only at the end of a line. Before inversion, vsync is high for whole lines during the vertical sync phase.
- R5: Before inversion, data enable is high only when both axes are in their active phase. While it is high, `pix_x`/`pix_y` give the column and row counted from 0. At all other times they are 0.
- R6: In `tim_pol`, bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data enable. Bit 3 drives `lcd_pclk_neg`, which selects launch on the falling pixel-clock edge.
- R7: `frame_start` is high for exactly one cycle, at the first pixel of the first active line.
- R8: `tim_pol[25:16]` must equal the active width minus 1. If it does not, data enable stays at its inactive level and `pix_x`/`pix_y` stay 0 for that frame, while the syncs and `frame_start` keep running.
- R9: The configuration words are sampled only at the frame boundary, or while the raster is stopped. A change in the middle of a frame first applies to the next frame.
- R10: The raster runs only while `lcd_en` and `lcd_pwr` are both high. Power without enable has no effect. While stopped, all outputs are 0. A restart begins at the first pixel of a frame.
- R11: All outputs are registered. During reset they are 0. The first pixel of a frame appears the cycle after the first clock edge that samples both controls high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tim_h | input | 32 | Horizontal timing word |
| tim_v | input | 32 | Vertical timing word |
| tim_pol | input | 32 | Polarity, clock edge and line-length word |
| lcd_en | input | 1 | Timing enable |
| lcd_pwr | input | 1 | Panel power |
| lcd_hsync | output | 1 | Horizontal sync |
| lcd_vsync | output | 1 | Vertical sync |
| lcd_de | output | 1 | Data enable |
| lcd_pclk_neg | output | 1 | Launch data on the falling edge |
| pix_x | output | 10 | Active column |
| pix_y | output | 10 | Active row |
| frame_start | output | 1 | First-pixel strobe |

## Verification
The assertions take for granted that the configuration words change only between clock edges, and that a new word is in place at least one edge before the raster is enabled. The frame-start pulse check relies on every line having at least 16 active pixels, which the width encoding guarantees. The stimulus changes inputs only on falling edges. It always writes new words while the raster is stopped, with one idle cycle before the enable, except in the deliberate mid-frame write test. The sweep keeps every field inside its encoded range, including the all-ones corner cases.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;
  parameter int REG_W = 32;
  parameter int CW    = 11;
  parameter int XW    = 10;
  parameter int YW    = 10;

  localparam int H_PPL_LO = 2;
  localparam int H_PPL_W  = 6;
  localparam int H_SW_LO  = 8;
  localparam int H_FP_LO  = 16;
  localparam int H_BP_LO  = 24;
  localparam int H_FLD_W  = 8;
  localparam int V_ACT_LO = 0;
  localparam int V_ACT_W  = 10;
  localparam int V_SW_LO  = 10;
  localparam int V_SW_W   = 6;
  localparam int V_FP_LO  = 16;
  localparam int V_BP_LO  = 24;
  localparam int V_FLD_W  = 8;
  localparam int P_INV_W  = 4;
  localparam int P_CPL_LO = 16;
  localparam int P_CPL_W  = 10;
  localparam int GRAN_SH  = 4;

  typedef enum logic [1:0] {
    PH_ACT  = 2'd0,
    PH_FP   = 2'd1,
    PH_SYNC = 2'd2,
    PH_BP   = 2'd3
  } tg_phase_e;
endpackage

// File: rtl/lcd_tgen_cfg.sv
module lcd_tgen_cfg
  import lcd_tgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [REG_W-1:0] tim_h_i,
  input  logic [REG_W-1:0] tim_v_i,
  input  logic [REG_W-1:0] tim_pol_i,
  output logic [CW-1:0]    h_act_o,
  output logic [CW-1:0]    h_fp_o,
  output logic [CW-1:0]    h_sw_o,
  output logic [CW-1:0]    h_bp_o,
  output logic [CW-1:0]    v_act_o,
  output logic [CW-1:0]    v_fp_o,
  output logic [CW-1:0]    v_sw_o,
  output logic [CW-1:0]    v_bp_o,
  output logic [P_INV_W-1:0] inv_o,
  output logic             geom_ok_o
);
  logic [H_PPL_W-1:0] ppl_q, ppl_d;
  logic [H_FLD_W-1:0] hsw_q, hsw_d, hfp_q, hfp_d, hbp_q, hbp_d;
  logic [V_ACT_W-1:0] lpp_q, lpp_d;
  logic [V_SW_W-1:0]  vsw_q, vsw_d;
  logic [V_FLD_W-1:0] vfp_q, vfp_d, vbp_q, vbp_d;
  logic [P_INV_W-1:0] inv_q, inv_d;
  logic [P_CPL_W-1:0] cpl_q, cpl_d;
  logic               unused_cfg_bits;

  assign unused_cfg_bits = ^{tim_h_i[H_PPL_LO-1:0],
                             tim_pol_i[P_CPL_LO-1:P_INV_W],
                             tim_pol_i[REG_W-1:P_CPL_LO+P_CPL_W]};

  always_comb begin
    ppl_d = ppl_q; hsw_d = hsw_q; hfp_d = hfp_q; hbp_d = hbp_q;
    lpp_d = lpp_q; vsw_d = vsw_q; vfp_d = vfp_q; vbp_d = vbp_q;
    inv_d = inv_q; cpl_d = cpl_q;
    if (load_i) begin
      ppl_d = tim_h_i[H_PPL_LO +: H_PPL_W];
      hsw_d = tim_h_i[H_SW_LO  +: H_FLD_W];
      hfp_d = tim_h_i[H_FP_LO  +: H_FLD_W];
      hbp_d = tim_h_i[H_BP_LO  +: H_FLD_W];
      lpp_d = tim_v_i[V_ACT_LO +: V_ACT_W];
      vsw_d = tim_v_i[V_SW_LO  +: V_SW_W];
      vfp_d = tim_v_i[V_FP_LO  +: V_FLD_W];
      vbp_d = tim_v_i[V_BP_LO  +: V_FLD_W];
      inv_d = tim_pol_i[P_INV_W-1:0];
      cpl_d = tim_pol_i[P_CPL_LO +: P_CPL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppl_q <= '0; hsw_q <= '0; hfp_q <= '0; hbp_q <= '0;
      lpp_q <= '0; vsw_q <= '0; vfp_q <= '0; vbp_q <= '0;
      inv_q <= '0; cpl_q <= '0;
    end else if (load_i) begin
      ppl_q <= ppl_d; hsw_q <= hsw_d; hfp_q <= hfp_d; hbp_q <= hbp_d;
      lpp_q <= lpp_d; vsw_q <= vsw_d; vfp_q <= vfp_d; vbp_q <= vbp_d;
      inv_q <= inv_d; cpl_q <= cpl_d;
    end
  end

  always_comb begin
    h_act_o = CW'({(CW-GRAN_SH)'(ppl_q) + (CW-GRAN_SH)'(1), {GRAN_SH{1'b0}}});
    h_sw_o  = CW'(hsw_q) + CW'(1);
    h_fp_o  = CW'(hfp_q) + CW'(1);
    h_bp_o  = CW'(hbp_q) + CW'(1);
    v_act_o = CW'(lpp_q) + CW'(1);
    v_sw_o  = CW'(vsw_q) + CW'(1);
    v_fp_o  = CW'(vfp_q);
    v_bp_o  = CW'(vbp_q);
    inv_o   = inv_q;
    geom_ok_o = (CW'(cpl_q) == (h_act_o - CW'(1)));
  end
endmodule

// File: rtl/lcd_tgen_axis.sv
module lcd_tgen_axis
  import lcd_tgen_pkg::*;
#(
  parameter bit PORCH_MAY_BE_ZERO = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [CW-1:0] len_act_i,
  input  logic [CW-1:0] len_fp_i,
  input  logic [CW-1:0] len_sw_i,
  input  logic [CW-1:0] len_bp_i,
  output tg_phase_e     ph_o,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  tg_phase_e     ph_q, ph_d, ph_nxt;
  logic [CW-1:0] cnt_q, cnt_d, cur_len;
  logic          at_end, final_ph, fp_skip, bp_skip, upd;

  generate
    if (PORCH_MAY_BE_ZERO) begin : g_skip
      assign fp_skip = (len_fp_i == '0);
      assign bp_skip = (len_bp_i == '0);
    end else begin : g_noskip
      assign fp_skip = 1'b0;
      assign bp_skip = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (ph_q)
      PH_ACT:  begin cur_len = len_act_i; ph_nxt = fp_skip ? PH_SYNC : PH_FP;  end
      PH_FP:   begin cur_len = len_fp_i;  ph_nxt = PH_SYNC;                     end
      PH_SYNC: begin cur_len = len_sw_i;  ph_nxt = bp_skip ? PH_ACT : PH_BP;   end
      default: begin cur_len = len_bp_i;  ph_nxt = PH_ACT;                      end
    endcase
    at_end   = (cnt_q == (cur_len - CW'(1)));
    final_ph = (ph_q == PH_BP) || ((ph_q == PH_SYNC) && bp_skip);
    wrap_o   = step_i && !clr_i && at_end && final_ph;
    upd      = clr_i || step_i;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      ph_d  = PH_ACT;
      cnt_d = '0;
    end else if (step_i) begin
      if (at_end) begin
        ph_d  = ph_nxt;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_ACT;
      cnt_q <= '0;
    end else if (upd) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign ph_o  = ph_q;
  assign cnt_o = cnt_q;

  // R2 / R4: the position never leaves the length of its phase
  p_cnt_in_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < cur_len);
  // R3: a zero-length porch is never entered
  p_no_empty_porch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_FP) |-> (len_fp_i != '0)) and ((ph_q == PH_BP) |-> (len_bp_i != '0)));
endmodule

// File: rtl/lcd_tgen_out.sv
module lcd_tgen_out
  import lcd_tgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  tg_phase_e          h_ph_i,
  input  logic [CW-1:0]      h_cnt_i,
  input  tg_phase_e          v_ph_i,
  input  logic [CW-1:0]      v_cnt_i,
  input  logic               ok_i,
  input  logic [P_INV_W-1:0] inv_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               pclk_neg_o,
  output logic [XW-1:0]      x_o,
  output logic [YW-1:0]      y_o,
  output logic               fs_o
);
  logic          hs_d, vs_d, de_d, pn_d, fs_d, de_int;
  logic [XW-1:0] x_d;
  logic [YW-1:0] y_d;

  always_comb begin
    de_int = (h_ph_i == PH_ACT) && (v_ph_i == PH_ACT) && ok_i;
    hs_d = 1'b0; vs_d = 1'b0; de_d = 1'b0; pn_d = 1'b0; fs_d = 1'b0;
    x_d  = '0;   y_d  = '0;
    if (run_i) begin
      hs_d = (h_ph_i == PH_SYNC) ^ inv_i[0];
      vs_d = (v_ph_i == PH_SYNC) ^ inv_i[1];
      de_d = de_int ^ inv_i[2];
      pn_d = inv_i[3];
      fs_d = (h_ph_i == PH_ACT) && (h_cnt_i == '0) &&
             (v_ph_i == PH_ACT) && (v_cnt_i == '0);
      if (de_int) begin
        x_d = h_cnt_i[XW-1:0];
        y_d = v_cnt_i[YW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_o <= 1'b0; vsync_o <= 1'b0; de_o <= 1'b0; pclk_neg_o <= 1'b0;
      x_o <= '0; y_o <= '0; fs_o <= 1'b0;
    end else begin
      hsync_o <= hs_d; vsync_o <= vs_d; de_o <= de_d; pclk_neg_o <= pn_d;
      x_o <= x_d; y_o <= y_d; fs_o <= fs_d;
    end
  end

  // R10: stopped raster yields all-low outputs one cycle later
  p_idle_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> ({hsync_o, vsync_o, de_o, pclk_neg_o, fs_o} == '0) && (x_o == '0) && (y_o == '0));
  // R7: frame strobe lasts one cycle
  p_fs_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fs_o |=> !fs_o);
  // R8: geometry mismatch holds data enable inactive
  p_blank_on_mismatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !ok_i) |=> (de_o == $past(inv_i[2])) && (x_o == '0) && (y_o == '0));
  // R5: outside the horizontal active phase data enable is inactive
  p_de_needs_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (h_ph_i != PH_ACT)) |=> (de_o == $past(inv_i[2])));
endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen
  import lcd_tgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] tim_h,
  input  logic [REG_W-1:0] tim_v,
  input  logic [REG_W-1:0] tim_pol,
  input  logic             lcd_en,
  input  logic             lcd_pwr,
  output logic             lcd_hsync,
  output logic             lcd_vsync,
  output logic             lcd_de,
  output logic             lcd_pclk_neg,
  output logic [XW-1:0]    pix_x,
  output logic [YW-1:0]    pix_y,
  output logic             frame_start
);
  logic [1:0]         rst_sync_q;
  logic               rst_s, run, h_wrap, v_wrap, load, geom_ok;
  logic [CW-1:0]      h_act, h_fp, h_sw, h_bp, v_act, v_fp, v_sw, v_bp;
  logic [CW-1:0]      h_cnt, v_cnt;
  logic [P_INV_W-1:0] inv;
  tg_phase_e          h_ph, v_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign run  = lcd_en && lcd_pwr;
  assign load = !run || v_wrap;

  lcd_tgen_cfg u_cfg (
    .clk(clk), .rst_n(rst_s), .load_i(load),
    .tim_h_i(tim_h), .tim_v_i(tim_v), .tim_pol_i(tim_pol),
    .h_act_o(h_act), .h_fp_o(h_fp), .h_sw_o(h_sw), .h_bp_o(h_bp),
    .v_act_o(v_act), .v_fp_o(v_fp), .v_sw_o(v_sw), .v_bp_o(v_bp),
    .inv_o(inv), .geom_ok_o(geom_ok)
  );

  lcd_tgen_axis #(.PORCH_MAY_BE_ZERO(1'b0)) u_hax (
    .clk(clk), .rst_n(rst_s), .clr_i(!run), .step_i(run),
    .len_act_i(h_act), .len_fp_i(h_fp), .len_sw_i(h_sw), .len_bp_i(h_bp),
    .ph_o(h_ph), .cnt_o(h_cnt), .wrap_o(h_wrap)
  );

  lcd_tgen_axis #(.PORCH_MAY_BE_ZERO(1'b1)) u_vax (
    .clk(clk), .rst_n(rst_s), .clr_i(!run), .step_i(h_wrap),
    .len_act_i(v_act), .len_fp_i(v_fp), .len_sw_i(v_sw), .len_bp_i(v_bp),
    .ph_o(v_ph), .cnt_o(v_cnt), .wrap_o(v_wrap)
  );

  lcd_tgen_out u_out (
    .clk(clk), .rst_n(rst_s), .run_i(run),
    .h_ph_i(h_ph), .h_cnt_i(h_cnt), .v_ph_i(v_ph), .v_cnt_i(v_cnt),
    .ok_i(geom_ok), .inv_i(inv),
    .hsync_o(lcd_hsync), .vsync_o(lcd_vsync), .de_o(lcd_de),
    .pclk_neg_o(lcd_pclk_neg), .x_o(pix_x), .y_o(pix_y), .fs_o(frame_start)
  );

  // R4: the vertical position moves only when a line completes
  p_vhold_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (run && !h_wrap) |=> ($stable(v_cnt) && $stable(v_ph)));
  // R9: shadowed geometry is frozen inside a running frame
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (run && !v_wrap) |=> ($stable(h_act) && $stable(v_act) && $stable(inv) && $stable(geom_ok)));
endmodule

// File: tb/sim_lcd_tgen.sv
module sim_lcd_tgen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] tim_h, tim_v, tim_pol;
  logic        lcd_en, lcd_pwr;
  logic        lcd_hsync, lcd_vsync, lcd_de, lcd_pclk_neg, frame_start;
  logic [9:0]  pix_x, pix_y;

  int          n_chk = 0;
  int          n_bad = 0;
  int          pos = 0;
  bit          done = 1'b0;
  logic [31:0] cur_h = '0, cur_v = '0, cur_p = '0;

  always #10 clk = ~clk;

  lcd_tgen u0 (
    .clk(clk), .rst_n(rst_n), .tim_h(tim_h), .tim_v(tim_v), .tim_pol(tim_pol),
    .lcd_en(lcd_en), .lcd_pwr(lcd_pwr), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
    .lcd_de(lcd_de), .lcd_pclk_neg(lcd_pclk_neg), .pix_x(pix_x), .pix_y(pix_y),
    .frame_start(frame_start)
  );

  function automatic logic [31:0] pack_h(int w, int hf, int hs, int hb);
    return {8'(hb - 1), 8'(hf - 1), 8'(hs - 1), 6'(w / 16 - 1), 2'b00};
  endfunction
  function automatic logic [31:0] pack_v(int va, int vs, int vf, int vb);
    return {8'(vb), 8'(vf), 6'(vs - 1), 10'(va - 1)};
  endfunction
  function automatic logic [31:0] pack_p(int inv, int cpl);
    return {6'b0, 10'(cpl), 12'b0, 4'(inv)};
  endfunction

  function automatic int frame_len(logic [31:0] h, logic [31:0] v);
    int ht, vt;
    ht = (int'(h[7:2]) + 1) * 16 + int'(h[23:16]) + int'(h[15:8]) + int'(h[31:24]) + 3;
    vt = int'(v[9:0]) + 1 + int'(v[15:10]) + 1 + int'(v[23:16]) + int'(v[31:24]);
    return ht * vt;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step_one(string ctx);
    int w, hf, hs, hb, va, vs, vf, vb, ht, line, col, ex, ey;
    bit hact, hsy, vact, vsy, ok, de_i;
    @(negedge clk);
    if (lcd_en && lcd_pwr && rst_n) begin
      w  = (int'(cur_h[7:2]) + 1) * 16;
      hf = int'(cur_h[23:16]) + 1;
      hs = int'(cur_h[15:8]) + 1;
      hb = int'(cur_h[31:24]) + 1;
      va = int'(cur_v[9:0]) + 1;
      vs = int'(cur_v[15:10]) + 1;
      vf = int'(cur_v[23:16]);
      vb = int'(cur_v[31:24]);
      ht = w + hf + hs + hb;
      line = pos / ht;
      col  = pos % ht;
      hact = (col < w);
      hsy  = (col >= w + hf) && (col < w + hf + hs);
      vact = (line < va);
      vsy  = (line >= va + vf) && (line < va + vf + vs);
      ok   = (int'(cur_p[25:16]) == w - 1);
      de_i = hact && vact && ok;
      ex = de_i ? col : 0;
      ey = de_i ? line : 0;
      chk({ctx, " R2 R6 (R1 decode)"}, "hsync", int'(lcd_hsync), int'(hsy ^ cur_p[0]));
      chk({ctx, " R4 R6 (R3 decode)"}, "vsync", int'(lcd_vsync), int'(vsy ^ cur_p[1]));
      chk({ctx, " R5 R6 R8"}, "de", int'(lcd_de), int'(de_i ^ cur_p[2]));
      chk({ctx, " R6"}, "pclk_neg", int'(lcd_pclk_neg), int'(cur_p[3]));
      chk({ctx, " R5"}, "pix_x", int'(pix_x), ex);
      chk({ctx, " R5"}, "pix_y", int'(pix_y), ey);
      chk({ctx, " R7 R11"}, "frame_start", int'(frame_start), int'(pos == 0));
      pos++;
      if (pos >= ht * (va + vs + vf + vb)) begin
        pos = 0;
        cur_h = tim_h; cur_v = tim_v; cur_p = tim_pol;
      end
    end else begin
      chk({ctx, " R10"}, "idle outputs",
          int'({lcd_hsync, lcd_vsync, lcd_de, lcd_pclk_neg, frame_start, pix_x, pix_y}), 0);
      pos = 0;
      cur_h = tim_h; cur_v = tim_v; cur_p = tim_pol;
    end
  endtask

  task automatic run_n(string ctx, int n);
    for (int k = 0; k < n; k++) step_one(ctx);
  endtask

  task automatic start_cfg(logic [31:0] h, logic [31:0] v, logic [31:0] p);
    lcd_en = 1'b0; lcd_pwr = 1'b0;
    step_one("R10");
    tim_h = h; tim_v = v; tim_pol = p;
    step_one("R10");
    lcd_en = 1'b1; lcd_pwr = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; lcd_en = 1'b0; lcd_pwr = 1'b0;
    tim_h = '0; tim_v = '0; tim_pol = '0;
    run_n("R11 reset", 3);
    rst_n = 1'b1;
    run_n("R11 after reset", 3);

    // R10: power alone, then enable alone, must not start the raster
    tim_h = pack_h(16, 1, 1, 1); tim_v = pack_v(2, 1, 0, 0); tim_pol = pack_p(4'hF, 15);
    lcd_pwr = 1'b1;
    run_n("R10 pwr only", 6);
    lcd_pwr = 1'b0; lcd_en = 1'b1;
    run_n("R10 en only", 6);

    // R1-R7 sweep over small geometries and polarities
    for (int i = 0; i < 64; i++) begin
      int w, hf, hs, hb, va, vs, vf, vb, inv;
      w  = 16 * (1 + (i & 1));
      hf = 1 + 2 * ((i >> 1) & 1);
      hs = 1 + ((i >> 2) & 1);
      hb = 1 + ((i >> 3) & 1);
      va = 1 + 2 * ((i >> 4) & 1);
      vs = 1 + ((i >> 5) & 1);
      vf = 2 * (((i >> 2) ^ (i >> 4)) & 1);
      vb = (i ^ (i >> 5)) & 1;
      inv = (i ^ (i >> 2)) & 15;
      start_cfg(pack_h(w, hf, hs, hb), pack_v(va, vs, vf, vb), pack_p(inv, w - 1));
      run_n("sweep", 2 * frame_len(tim_h, tim_v) + 3);
      if ((i & 1) != 0) lcd_pwr = 1'b0; else lcd_en = 1'b0;
      run_n("R10 stop", 2);
    end

    // R1 / R3: widest encodable fields
    start_cfg(pack_h(1024, 256, 256, 256), pack_v(1, 1, 0, 0), pack_p(0, 1023));
    run_n("R1 max horizontal", frame_len(tim_h, tim_v) + 2);
    start_cfg(pack_h(16, 1, 1, 1), pack_v(4, 64, 255, 255), pack_p(2, 15));
    run_n("R3 max vertical", frame_len(tim_h, tim_v) + 2);

    // R8: line-length field disagrees with width
    start_cfg(pack_h(32, 2, 2, 2), pack_v(2, 1, 1, 1), pack_p(4, 16));
    run_n("R8 mismatch", frame_len(tim_h, tim_v) + 5);

    // R9: mid-frame write applies only from the next frame
    start_cfg(pack_h(16, 1, 2, 1), pack_v(3, 1, 1, 0), pack_p(0, 15));
    run_n("R9 before write", 30);
    tim_h = pack_h(32, 3, 1, 2); tim_v = pack_v(2, 2, 0, 1); tim_pol = pack_p(7, 31);
    run_n("R9 after write", 3 * frame_len(tim_h, tim_v));

    // R10: restart after power loss begins at frame start
    lcd_pwr = 1'b0;
    run_n("R10 power drop", 3);
    lcd_pwr = 1'b1;
    run_n("R10 restart", frame_len(tim_h, tim_v) + 4);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R11 actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule